// File: doc/BRIEF.md
# Two-Word Control Port Command Latch

This block sits behind the control port of a display controller's host interface. The host uses two consecutive writes to deliver one access command. The first word carries the low 14 address bits and the two low command-code bits. The second word carries the top two address bits and the four upper command-code bits. The block keeps the 16-bit address and the 6-bit command code in registers, and it tracks whether the first word has arrived and the second is still due.

When a command completes, the block tells the read-prefetch logic to drop whatever it has fetched. It also decides whether a DMA should begin. A command that requests DMA either starts at once or, for a fill, waits for the next data-port write. Any data-port access or status read in the middle of a command aborts the half-written command. The block also builds the status word returned on status reads. In that word the FIFO empty and full indicators sit at their fixed positions and every other bit is zero.

Top module: `cmd_latch`

## Requirements
- R1: A control write with pending low is a first word: address[13:0] takes data[13:0], code[1:0] takes data[15:14], address[15:14] and code[5:2] keep their values, and pending is high one cycle later.
- R2: A control write with pending high is a second word: address[15:14] takes data[1:0], code[5:2] takes data[7:4], the low address and code bits keep their values, and pending is low one cycle later.
- R3: A completed second word raises `fetch_clr` for exactly one cycle, in the cycle after the write. A first word never raises it.
- R4: If the second word sets code bit 5 (data[7]) while `dma_en` is high and `src_hi` is not 2'b10, `dma_go` is high for exactly the cycle after that write.
- R5: If the second word requests DMA with `src_hi` equal to 2'b10 (fill), `dma_go` stays low. It then pulses for one cycle after the next data-port write. Data reads do not trigger it.
- R6: With `dma_en` low, or with code bit 5 clear in the second word, no DMA start follows.
- R7: A data-port read or write while pending clears pending and raises `fetch_clr` one cycle later. With pending low, these accesses leave `fetch_clr` low.
- R8: A status read (`ctrl_rd`) clears pending one cycle later and does not raise `fetch_clr`.
- R9: `status_word` bit 9 equals `fifo_empty` and bit 8 equals `fifo_full` in the same cycle. All other bits, including 15:10, are zero.
- R10: A control write in the same cycle as a status read or a data access is decoded as the write alone. The other strobes have no effect in that cycle.
- R11: After reset, the address, code, pending, `fetch_clr` and `dma_go` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control-port write strobe, one cycle per word |
| ctrl_wdata | input | 16 | Control-port write data |
| ctrl_rd | input | 1 | Status (control-port) read strobe |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe |
| dma_en | input | 1 | DMA-enable mode bit |
| src_hi | input | 2 | DMA source high bits 7:6; 2'b10 selects fill |
| fifo_empty | input | 1 | Write FIFO empty indicator |
| fifo_full | input | 1 | Write FIFO full indicator |
| addr | output | 16 | Assembled access address |
| code | output | 6 | Assembled command code |
| pending | output | 1 | First word received, second word due |
| fetch_clr | output | 1 | One-cycle strobe: clear read-fetched and read-pending flags |
| dma_go | output | 1 | One-cycle DMA start request |
| status_word | output | 16 | Status read value |

## Verification
All register results (address, code, pending, `fetch_clr`, `dma_go`) come from a single register stage. They change at the first rising edge after the strobe. The bench drives each strobe at a falling edge, holds it through one rising edge, and samples at the next falling edge, which is the one cycle in which the one-cycle pulses are visible. `status_word` is combinational, so it is sampled in the same cycle its inputs settle. For a fill, the start is checked twice: absent in the cycle after the second word and after an intervening data read, then present in the cycle after the data write.

// File: rtl/cmd_latch_pkg.sv
// Package: shared widths, field positions and event type for the
// two-word control port command latch.
// Assumes a 16-bit host word; field positions follow the command format.
package cmd_latch_pkg;

    localparam int WORD_W      = 16;
    localparam int ADDR_W      = 16;
    localparam int CODE_W      = 6;
    // Low address bits carried by the first word
    localparam int ADDR_LO_W   = 14;
    // Low code bits carried by the first word
    localparam int CODE_LO_W   = 2;
    // Bit position in the second word where upper code bits begin
    localparam int CODE_HI_LSB = 4;
    // Source-high encoding that marks a fill transfer
    localparam logic [1:0] SRC_FILL = 2'b10;
    // Status word positions of the FIFO indicators
    localparam int STAT_EMPTY_BIT = 9;
    localparam int STAT_FULL_BIT  = 8;

    // Decoded per-cycle host events
    typedef struct packed {
        logic first_word;   // control write taken as first word
        logic second_word;  // control write taken as second word
        logic data_abort;   // data access cancelling a pending command
        logic stat_abort;   // status read cancelling a pending command
        logic data_write;   // data write not masked by a control write
    } host_ev_t;

endpackage

// File: rtl/cmd_latch_evdec.sv
// Event decoder: turns the raw port strobes and the pending state into
// one-hot-ish command events. A control write masks every other strobe
// in the same cycle. Assumes strobes are single-cycle pulses.
module cmd_latch_evdec
    import cmd_latch_pkg::*;
(
    input  logic     ctrl_wr,
    input  logic     ctrl_rd,
    input  logic     data_wr,
    input  logic     data_rd,
    input  logic     pending,
    output host_ev_t ev
);

    // Purpose: classify this cycle's host access.
    always_comb begin
        ev             = '0;
        if (ctrl_wr) begin
            ev.first_word  = !pending;
            ev.second_word = pending;
        end else begin
            ev.data_abort  = pending && (data_wr || data_rd);
            ev.stat_abort  = pending && ctrl_rd && !(data_wr || data_rd);
            ev.data_write  = data_wr;
        end
    end

endmodule

// File: rtl/cmd_latch_words.sv
// Word assembler: holds the address, command code and pending flag and
// merges each control word into its fields. Also issues the one-cycle
// prefetch-clear strobe on command completion or abort by data access.
// Assumes events arrive from cmd_latch_evdec.
module cmd_latch_words
    import cmd_latch_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_CODE_W = CODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  host_ev_t            ev,
    input  logic [P_WORD_W-1:0] wdata,
    output logic [P_ADDR_W-1:0] addr,
    output logic [P_CODE_W-1:0] code,
    output logic                pending,
    output logic                fetch_clr
);

    localparam int A_HI_W = P_ADDR_W - ADDR_LO_W;
    localparam int C_HI_W = P_CODE_W - CODE_LO_W;
    localparam int C_LO_LSB = P_WORD_W - CODE_LO_W;

    // Purpose: merge control words into address and code fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            code <= '0;
        end else if (ev.first_word) begin
            addr[ADDR_LO_W-1:0] <= wdata[ADDR_LO_W-1:0];
            code[CODE_LO_W-1:0] <= wdata[C_LO_LSB +: CODE_LO_W];
        end else if (ev.second_word) begin
            addr[P_ADDR_W-1:ADDR_LO_W] <= wdata[A_HI_W-1:0];
            code[P_CODE_W-1:CODE_LO_W] <= wdata[CODE_HI_LSB +: C_HI_W];
        end
    end

    // Purpose: track whether the second word is still due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (ev.first_word) begin
            pending <= 1'b1;
        end else if (ev.second_word || ev.data_abort || ev.stat_abort) begin
            pending <= 1'b0;
        end
    end

    // Purpose: one-cycle strobe to drop prefetched read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_clr <= 1'b0;
        end else begin
            fetch_clr <= ev.second_word || ev.data_abort;
        end
    end

endmodule

// File: rtl/cmd_latch_dma.sv
// DMA start decision: on a completed command with the DMA code bit set
// and DMA enabled, requests a start at once, or for fill transfers arms
// a wait that fires on the next data-port write. Assumes the command
// bit is the top bit of the upper code field in the second word.
module cmd_latch_dma
    import cmd_latch_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_CODE_W = CODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  host_ev_t            ev,
    input  logic [P_WORD_W-1:0] wdata,
    input  logic                dma_en,
    input  logic [1:0]          src_hi,
    output logic                dma_go
);

    // Second-word bit that lands in the top code bit
    localparam int DMA_BIT = CODE_HI_LSB + (P_CODE_W - CODE_LO_W) - 1;

    logic want_dma;
    logic is_fill;
    logic fill_wait;

    // Purpose: decide whether the completing command asks for DMA.
    always_comb begin
        want_dma = ev.second_word && wdata[DMA_BIT] && dma_en;
        is_fill  = (src_hi == SRC_FILL);
    end

    // Purpose: hold a fill request until the data write that feeds it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_wait <= 1'b0;
        end else if (ev.second_word) begin
            fill_wait <= want_dma && is_fill;
        end else if (ev.data_write) begin
            fill_wait <= 1'b0;
        end
    end

    // Purpose: one-cycle start request, immediate or fill-triggered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_go <= 1'b0;
        end else begin
            dma_go <= (want_dma && !is_fill) || (fill_wait && ev.data_write);
        end
    end

endmodule

// File: rtl/cmd_latch_status.sv
// Status formatter: places the FIFO indicators in the status word and
// returns zero in every other bit. Purely combinational.
module cmd_latch_status
    import cmd_latch_pkg::*;
#(
    parameter int P_WORD_W = WORD_W
) (
    input  logic                fifo_empty,
    input  logic                fifo_full,
    output logic [P_WORD_W-1:0] status_word
);

    // Purpose: assemble the status word from the FIFO indicators.
    always_comb begin
        status_word                 = '0;
        status_word[STAT_EMPTY_BIT] = fifo_empty;
        status_word[STAT_FULL_BIT]  = fifo_full;
    end

endmodule

// File: rtl/cmd_latch.sv
// Top: two-word control port command latch. Wires the event decoder,
// the word assembler, the DMA start decision and the status formatter.
// Assumes single-cycle host strobes and a synchronous active-low reset.
module cmd_latch
    import cmd_latch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [WORD_W-1:0] ctrl_wdata,
    input  logic              ctrl_rd,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic              dma_en,
    input  logic [1:0]        src_hi,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    output logic [ADDR_W-1:0] addr,
    output logic [CODE_W-1:0] code,
    output logic              pending,
    output logic              fetch_clr,
    output logic              dma_go,
    output logic [WORD_W-1:0] status_word
);

    host_ev_t ev;

    cmd_latch_evdec u_evdec (
        .ctrl_wr (ctrl_wr),
        .ctrl_rd (ctrl_rd),
        .data_wr (data_wr),
        .data_rd (data_rd),
        .pending (pending),
        .ev      (ev)
    );

    cmd_latch_words #(
        .P_WORD_W (WORD_W),
        .P_ADDR_W (ADDR_W),
        .P_CODE_W (CODE_W)
    ) u_words (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .wdata     (ctrl_wdata),
        .addr      (addr),
        .code      (code),
        .pending   (pending),
        .fetch_clr (fetch_clr)
    );

    cmd_latch_dma #(
        .P_WORD_W (WORD_W),
        .P_CODE_W (CODE_W)
    ) u_dma (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .wdata  (ctrl_wdata),
        .dma_en (dma_en),
        .src_hi (src_hi),
        .dma_go (dma_go)
    );

    cmd_latch_status #(
        .P_WORD_W (WORD_W)
    ) u_status (
        .fifo_empty  (fifo_empty),
        .fifo_full   (fifo_full),
        .status_word (status_word)
    );

endmodule

// File: rtl/cmd_latch_chk.sv
// Checker: protocol properties of the command latch, bound to the top.
module cmd_latch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_wr,
    input logic [15:0] ctrl_wdata,
    input logic        ctrl_rd,
    input logic        data_wr,
    input logic        data_rd,
    input logic        dma_en,
    input logic [1:0]  src_hi,
    input logic        fifo_empty,
    input logic        fifo_full,
    input logic [15:0] addr,
    input logic [5:0]  code,
    input logic        pending,
    input logic        fetch_clr,
    input logic        dma_go,
    input logic [15:0] status_word
);

    // R1: first word fills low fields, keeps high fields, sets pending
    a_r1_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !pending) |=> (pending
            && addr[13:0] == $past(ctrl_wdata[13:0])
            && code[1:0] == $past(ctrl_wdata[15:14])
            && addr[15:14] == $past(addr[15:14])
            && code[5:2] == $past(code[5:2])));

    // R2: second word fills high fields, keeps low fields, clears pending
    a_r2_second_word: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && pending) |=> (!pending
            && addr[15:14] == $past(ctrl_wdata[1:0])
            && code[5:2] == $past(ctrl_wdata[7:4])
            && addr[13:0] == $past(addr[13:0])
            && code[1:0] == $past(code[1:0])));

    // R3: the prefetch clear follows a completed command
    a_r3_clr_on_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && pending) |=> fetch_clr);

    // R3: a first word never clears the prefetch
    a_r3_no_clr_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !pending) |=> !fetch_clr);

    // R4: an immediate DMA start follows a non-fill DMA command
    a_r4_dma_now: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && pending && ctrl_wdata[7] && dma_en && src_hi != 2'b10)
            |=> dma_go);

    // R5: a fill command does not start at once
    a_r5_fill_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && pending && src_hi == 2'b10) |=> !dma_go);

    // R6: no start without DMA enabled
    a_r6_no_dma_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && pending && !dma_en) |=> !dma_go);

    // R7: a data access while pending aborts and clears the prefetch
    a_r7_data_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && pending && (data_wr || data_rd)) |=> (!pending && fetch_clr));

    // R8: a status read cancels pending without clearing the prefetch
    a_r8_status_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && ctrl_rd && !data_wr && !data_rd) |=> (!pending && !fetch_clr));

    // R9: FIFO indicators sit at bits 9 and 8, the rest is zero
    a_r9_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[9] == fifo_empty && status_word[8] == fifo_full
            && status_word[15:10] == 6'd0 && status_word[7:0] == 8'd0);

    // R11: pulses are zero in the first cycle after reset
    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pending && !fetch_clr && !dma_go && addr == 16'd0));

endmodule

bind cmd_latch cmd_latch_chk u_chk (.*);

// File: tb/cmd_latch_tb.sv
// Bench for the command latch: a vector table walked by one loop, then
// directed checks for reset, status formatting and strobe collisions.
module cmd_latch_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] OP_CWR = 3'd0;
    localparam logic [2:0] OP_CRD = 3'd1;
    localparam logic [2:0] OP_DWR = 3'd2;
    localparam logic [2:0] OP_DRD = 3'd3;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] wd;
        logic        en;
        logic [1:0]  sh;
        logic [15:0] e_addr;
        logic [5:0]  e_code;
        logic        e_pend;
        logic        e_clr;
        logic        e_go;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{OP_CWR, 16'h4123, 1'b0, 2'b00, 16'h0123, 6'h01, 1'b1, 1'b0, 1'b0, 8'd1},
        '{OP_CWR, 16'h00F2, 1'b0, 2'b00, 16'h8123, 6'h3D, 1'b0, 1'b1, 1'b0, 8'd2},
        '{OP_CWR, 16'hC001, 1'b0, 2'b00, 16'h8001, 6'h3F, 1'b1, 1'b0, 1'b0, 8'd1},
        '{OP_CRD, 16'h0000, 1'b0, 2'b00, 16'h8001, 6'h3F, 1'b0, 1'b0, 1'b0, 8'd8},
        '{OP_CWR, 16'hC001, 1'b0, 2'b00, 16'h8001, 6'h3F, 1'b1, 1'b0, 1'b0, 8'd1},
        '{OP_CWR, 16'h0083, 1'b1, 2'b00, 16'hC001, 6'h23, 1'b0, 1'b1, 1'b1, 8'd4},
        '{OP_CWR, 16'h3FFF, 1'b1, 2'b00, 16'hFFFF, 6'h20, 1'b1, 1'b0, 1'b0, 8'd1},
        '{OP_DWR, 16'h0000, 1'b1, 2'b00, 16'hFFFF, 6'h20, 1'b0, 1'b1, 1'b0, 8'd7},
        '{OP_DRD, 16'h0000, 1'b1, 2'b00, 16'hFFFF, 6'h20, 1'b0, 1'b0, 1'b0, 8'd7},
        '{OP_CWR, 16'h0000, 1'b1, 2'b10, 16'hC000, 6'h20, 1'b1, 1'b0, 1'b0, 8'd1},
        '{OP_CWR, 16'h0080, 1'b1, 2'b10, 16'h0000, 6'h20, 1'b0, 1'b1, 1'b0, 8'd5},
        '{OP_DRD, 16'h0000, 1'b1, 2'b10, 16'h0000, 6'h20, 1'b0, 1'b0, 1'b0, 8'd5},
        '{OP_DWR, 16'h0000, 1'b1, 2'b10, 16'h0000, 6'h20, 1'b0, 1'b0, 1'b1, 8'd5},
        '{OP_DWR, 16'h0000, 1'b1, 2'b10, 16'h0000, 6'h20, 1'b0, 1'b0, 1'b0, 8'd5},
        '{OP_CWR, 16'h4000, 1'b1, 2'b01, 16'h0000, 6'h21, 1'b1, 1'b0, 1'b0, 8'd1},
        '{OP_CWR, 16'h0080, 1'b1, 2'b01, 16'h0000, 6'h21, 1'b0, 1'b1, 1'b1, 8'd4},
        '{OP_CWR, 16'h8000, 1'b1, 2'b11, 16'h0000, 6'h22, 1'b1, 1'b0, 1'b0, 8'd1},
        '{OP_DRD, 16'h0000, 1'b1, 2'b11, 16'h0000, 6'h22, 1'b0, 1'b1, 1'b0, 8'd7},
        '{OP_CWR, 16'h0000, 1'b0, 2'b00, 16'h0000, 6'h20, 1'b1, 1'b0, 1'b0, 8'd1},
        '{OP_CWR, 16'h00A0, 1'b0, 2'b00, 16'h0000, 6'h28, 1'b0, 1'b1, 1'b0, 8'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctrl_wr, ctrl_rd, data_wr, data_rd, dma_en;
    logic [15:0] ctrl_wdata;
    logic [1:0]  src_hi;
    logic        fifo_empty, fifo_full;
    logic [15:0] addr;
    logic [5:0]  code;
    logic        pending, fetch_clr, dma_go;
    logic [15:0] status_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = !clk;

    cmd_latch u_dut (
        .clk (clk), .rst_n (rst_n),
        .ctrl_wr (ctrl_wr), .ctrl_wdata (ctrl_wdata), .ctrl_rd (ctrl_rd),
        .data_wr (data_wr), .data_rd (data_rd),
        .dma_en (dma_en), .src_hi (src_hi),
        .fifo_empty (fifo_empty), .fifo_full (fifo_full),
        .addr (addr), .code (code), .pending (pending),
        .fetch_clr (fetch_clr), .dma_go (dma_go), .status_word (status_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_strobes();
        ctrl_wr = 1'b0; ctrl_rd = 1'b0; data_wr = 1'b0; data_rd = 1'b0;
    endtask

    // Drive one strobe cycle and land on the falling edge after it.
    task automatic pulse(input logic cw, input logic cr, input logic dw,
                         input logic dr, input logic [15:0] wd);
        @(negedge clk);
        ctrl_wr = cw; ctrl_rd = cr; data_wr = dw; data_rd = dr; ctrl_wdata = wd;
        @(negedge clk);
        idle_strobes();
    endtask

    task automatic check_regs(input string tag, input logic [15:0] ea, input logic [5:0] ec,
                              input logic ep, input logic ecl, input logic eg);
        check({tag, " addr"}, 32'(addr), 32'(ea));
        check({tag, " code"}, 32'(code), 32'(ec));
        check({tag, " pending"}, 32'(pending), 32'(ep));
        check({tag, " fetch_clr"}, 32'(fetch_clr), 32'(ecl));
        check({tag, " dma_go"}, 32'(dma_go), 32'(eg));
    endtask

    initial begin
        rst_n = 1'b0; idle_strobes(); ctrl_wdata = '0;
        dma_en = 1'b0; src_hi = 2'b00; fifo_empty = 1'b1; fifo_full = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check_regs("R11 reset", 16'h0000, 6'h00, 1'b0, 1'b0, 1'b0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            @(negedge clk);
            dma_en = VEC[i].en; src_hi = VEC[i].sh;
            pulse(VEC[i].op == OP_CWR, VEC[i].op == OP_CRD, VEC[i].op == OP_DWR,
                  VEC[i].op == OP_DRD, VEC[i].wd);
            check_regs(tag, VEC[i].e_addr, VEC[i].e_code, VEC[i].e_pend,
                       VEC[i].e_clr, VEC[i].e_go);
        end

        // R3: completion strobe lasts one cycle only
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 16'h0010);
        check("R3 clr high", 32'(fetch_clr), 32'd1);
        @(negedge clk);
        check("R3 clr one cycle", 32'(fetch_clr), 32'd0);

        // R9: status word for every FIFO indicator combination
        for (int k = 0; k < 4; k++) begin
            fifo_empty = k[1]; fifo_full = k[0];
            #1;
            check("R9 status", 32'(status_word), 32'({6'd0, k[1], k[0], 8'd0}));
        end

        // R10: control write wins over a simultaneous status read
        pulse(1'b1, 1'b1, 1'b0, 1'b0, 16'h0005);
        check("R10 cwr+crd pending", 32'(pending), 32'd1);
        check("R10 cwr+crd addr", 32'(addr[13:0]), 32'h0005);
        // R10: second word with a simultaneous data write: no fill trigger
        dma_en = 1'b1; src_hi = 2'b10;
        pulse(1'b1, 1'b0, 1'b1, 1'b0, 16'h0080);
        check("R10 cwr+dwr go", 32'(dma_go), 32'd0);
        check("R10 cwr+dwr pending", 32'(pending), 32'd0);
        pulse(1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
        check("R5 fill after collision", 32'(dma_go), 32'd1);

        // R11: reset mid-command clears state
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 16'h7FFF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check_regs("R11 re-reset", 16'h0000, 6'h00, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule